// File: doc/BRIEF.md
# Receive Byte DMA Channel

This block empties a serial receiver's one-byte holding register into memory without processor help. A byte arriving from the receiver is captured and a ready flag is raised. While the channel is enabled and transfers remain, the block requests a single-cycle memory write of that byte at the current pointer. Each granted write advances the pointer by one and lowers the remaining-transfer count by one. When the count reaches zero the channel raises an end-of-block pending flag and turns itself off.

Software programs the channel through a small register write port. Four registers are selected: control, pointer, count and priority. The request toward memory is qualified by the programmed priority level, which must beat a competing level supplied from outside.

The receive stream has no back-pressure. `rx_valid` is a one-cycle strobe, and the single holding register accepts every byte. A byte that lands on an untaken one replaces it and sets an overrun flag. On the memory side `mem_req` behaves as a valid and `mem_gnt` as a ready, and a write happens in a cycle where both are high. While waiting for a grant, the request holds its address and data stable. It drops only when software disables the channel, or when the competing level rises to meet or pass the channel's priority.

Top module: `rxdma_top`

## Requirements
- R1: `mem_req` is high only while the ready flag is set, the channel is enabled, the count is nonzero and the priority wins. It is combinational from the registered state and `compete_prio`.
- R2: The clock edge that completes a write clears the ready flag (`rx_full`), unless a new byte arrives in that same cycle; in that case the flag stays set.
- R3: During a request, `mem_addr` equals the pointer and `mem_wdata` equals the held byte.
- R4: A completed write increments the pointer by one, modulo 2^ADDR_W, and decrements the count by one.
- R5: `cur_cnt` always shows the number of writes still to be performed.
- R6: A write that takes the count from 1 to 0 sets `eob_pend` and clears `dma_en` on the same edge.
- R7: Software clearing the enable bit withdraws an ungranted request from the next cycle on. A write granted on that same edge still completes, with its pointer and count updates.
- R8: A request is raised only when the programmed priority is strictly greater than `compete_prio`.
- R9: If the channel is enabled with a count of zero, then on the next edge `eob_pend` is set and `dma_en` is cleared. No write is performed and the pointer and ready flag are unchanged.
- R10: A byte arriving while the ready flag is set, in a cycle with no completing write, sets `ovr_flag` and replaces the held byte. The following write carries the newer byte.
- R11: After reset, `dma_en`, `eob_pend`, `ovr_flag`, `rx_full`, `cur_addr` and `cur_cnt` are all zero.
- R12: The register select codes are 0 for control, 1 for pointer, 2 for count and 3 for priority. The control register uses bit 0 as the enable value, bit 1 as write-one-to-clear for `eob_pend`, and bit 2 as write-one-to-clear for `ovr_flag`. A software write to the pointer or count wins over a hardware update in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select |
| cfg_wdata | input | CFG_W | Register write data |
| rx_valid | input | 1 | New received byte strobe |
| rx_data | input | DATA_W | Received byte |
| compete_prio | input | PRIO_W | Competing priority level |
| mem_gnt | input | 1 | Memory grant |
| mem_req | output | 1 | Memory write request |
| mem_addr | output | ADDR_W | Write address |
| mem_wdata | output | DATA_W | Write data |
| rx_full | output | 1 | Ready flag: a byte awaits transfer |
| ovr_flag | output | 1 | Overrun pending |
| eob_pend | output | 1 | End-of-block pending |
| dma_en | output | 1 | Channel enable state |
| cur_addr | output | ADDR_W | Current pointer |
| cur_cnt | output | CNT_W | Remaining transfers |

## Verification
Two events can share one cycle: a granted write that empties the holding register, and the arrival of the next byte. The bench drives `rx_valid` and `mem_gnt` high in the same cycle. It then expects the ready flag to stay set, no overrun, the pointer and count to advance once, and the next request to carry the new byte. A second collision is tested by clearing the enable bit in the cycle a write is granted. Here the bench expects the write to finish with its pointer and count updates, and the request to be gone afterwards.

// File: rtl/rxdma_pkg.sv
package rxdma_pkg;
  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_ADDR = 2'd1,
    SEL_CNT  = 2'd2,
    SEL_PRIO = 2'd3
  } cfg_sel_e;

  localparam int CTRL_EN_BIT     = 0;
  localparam int CTRL_EOBCLR_BIT = 1;
  localparam int CTRL_OVRCLR_BIT = 2;
endpackage

// File: rtl/rxdma_rxbuf.sv
// One-entry receive holding register with ready flag and overrun detect.
module rxdma_rxbuf #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  input  logic              take,
  input  logic              ovr_clr,
  output logic              full,
  output logic [DATA_W-1:0] data,
  output logic              ovr
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full <= 1'b0;
      data <= '0;
      ovr  <= 1'b0;
    end else begin
      if (in_valid) data <= in_data;
      // a fresh byte keeps the flag set even when the old one leaves
      if (in_valid)  full <= 1'b1;
      else if (take) full <= 1'b0;
      if (in_valid && full && !take) ovr <= 1'b1;
      else if (ovr_clr)              ovr <= 1'b0;
    end
  end
endmodule

// File: rtl/rxdma_arb.sv
// Priority register and request qualification.
module rxdma_arb #(
  parameter int PRIO_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              prio_we,
  input  logic [PRIO_W-1:0] prio_wdata,
  input  logic [PRIO_W-1:0] compete,
  input  logic              want,
  output logic [PRIO_W-1:0] prio,
  output logic              req
);
  logic win;

  always_ff @(posedge clk) begin
    if (!rst_n)       prio <= '0;
    else if (prio_we) prio <= prio_wdata;
  end

  assign win = (prio > compete);
  assign req = want & win;
endmodule

// File: rtl/rxdma_chan.sv
// Pointer, count, enable and end-of-block state.
module rxdma_chan #(
  parameter int ADDR_W = 8,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_we,
  input  logic              ctrl_en,
  input  logic              eob_clr,
  input  logic              addr_we,
  input  logic [ADDR_W-1:0] addr_wdata,
  input  logic              cnt_we,
  input  logic [CNT_W-1:0]  cnt_wdata,
  input  logic              xfer,
  output logic              en,
  output logic [ADDR_W-1:0] addr,
  output logic [CNT_W-1:0]  cnt,
  output logic              eob,
  output logic              has_work
);
  localparam logic [CNT_W-1:0]  CNT_ONE  = CNT_W'(1);
  localparam logic [ADDR_W-1:0] ADDR_ONE = ADDR_W'(1);

  logic last_xfer;
  logic zero_hit;
  logic finish;

  assign has_work  = en && (cnt != '0);
  assign last_xfer = xfer && (cnt == CNT_ONE);
  assign zero_hit  = en && (cnt == '0) && !cnt_we;
  assign finish    = last_xfer || zero_hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en   <= 1'b0;
      addr <= '0;
      cnt  <= '0;
      eob  <= 1'b0;
    end else begin
      if (finish)       en <= 1'b0;
      else if (ctrl_we) en <= ctrl_en;

      if (finish)       eob <= 1'b1;
      else if (eob_clr) eob <= 1'b0;

      if (addr_we)   addr <= addr_wdata;
      else if (xfer) addr <= addr + ADDR_ONE;

      if (cnt_we)    cnt <= cnt_wdata;
      else if (xfer) cnt <= cnt - CNT_ONE;
    end
  end
endmodule

// File: rtl/rxdma_top.sv
module rxdma_top #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 8,
  parameter int CNT_W  = 8,
  parameter int PRIO_W = 3,
  parameter int CFG_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [CFG_W-1:0]  cfg_wdata,
  input  logic              rx_valid,
  input  logic [DATA_W-1:0] rx_data,
  input  logic [PRIO_W-1:0] compete_prio,
  input  logic              mem_gnt,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              rx_full,
  output logic              ovr_flag,
  output logic              eob_pend,
  output logic              dma_en,
  output logic [ADDR_W-1:0] cur_addr,
  output logic [CNT_W-1:0]  cur_cnt
);
  import rxdma_pkg::*;

  cfg_sel_e          sel;
  logic              wr_ctrl, wr_addr, wr_cnt, wr_prio;
  logic              xfer;
  logic              has_work;
  logic [DATA_W-1:0] held;
  logic [PRIO_W-1:0] prio_q;

  assign sel     = cfg_sel_e'(cfg_sel);
  assign wr_ctrl = cfg_we && (sel == SEL_CTRL);
  assign wr_addr = cfg_we && (sel == SEL_ADDR);
  assign wr_cnt  = cfg_we && (sel == SEL_CNT);
  assign wr_prio = cfg_we && (sel == SEL_PRIO);

  assign xfer = mem_req && mem_gnt;

  rxdma_rxbuf #(.DATA_W(DATA_W)) u_buf (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (rx_valid),
    .in_data  (rx_data),
    .take     (xfer),
    .ovr_clr  (wr_ctrl && cfg_wdata[CTRL_OVRCLR_BIT]),
    .full     (rx_full),
    .data     (held),
    .ovr      (ovr_flag)
  );

  rxdma_chan #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chan (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctrl_we    (wr_ctrl),
    .ctrl_en    (cfg_wdata[CTRL_EN_BIT]),
    .eob_clr    (wr_ctrl && cfg_wdata[CTRL_EOBCLR_BIT]),
    .addr_we    (wr_addr),
    .addr_wdata (cfg_wdata[ADDR_W-1:0]),
    .cnt_we     (wr_cnt),
    .cnt_wdata  (cfg_wdata[CNT_W-1:0]),
    .xfer       (xfer),
    .en         (dma_en),
    .addr       (cur_addr),
    .cnt        (cur_cnt),
    .eob        (eob_pend),
    .has_work   (has_work)
  );

  rxdma_arb #(.PRIO_W(PRIO_W)) u_arb (
    .clk        (clk),
    .rst_n      (rst_n),
    .prio_we    (wr_prio),
    .prio_wdata (cfg_wdata[PRIO_W-1:0]),
    .compete    (compete_prio),
    .want       (has_work && rx_full),
    .prio       (prio_q),
    .req        (mem_req)
  );

  assign mem_addr  = cur_addr;
  assign mem_wdata = held;
endmodule

// File: rtl/rxdma_chk.sv
module rxdma_chk #(
  parameter int ADDR_W = 8,
  parameter int CNT_W  = 8,
  parameter int PRIO_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_we,
  input logic              rx_valid,
  input logic              mem_req,
  input logic              mem_gnt,
  input logic              rx_full,
  input logic              dma_en,
  input logic              eob_pend,
  input logic              ovr_flag,
  input logic [ADDR_W-1:0] cur_addr,
  input logic [CNT_W-1:0]  cur_cnt,
  input logic [PRIO_W-1:0] prio_q,
  input logic [PRIO_W-1:0] compete_prio
);
  logic xfer;
  assign xfer = mem_req && mem_gnt;

  assert_req_qualified_R1: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (rx_full && dma_en && cur_cnt != '0));

  assert_flag_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && !rx_valid) |=> !rx_full);

  assert_addr_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && !cfg_we) |=> cur_addr == $past(cur_addr) + ADDR_W'(1));

  assert_cnt_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && !cfg_we) |=> cur_cnt == $past(cur_cnt) - CNT_W'(1));

  assert_last_ends_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && cur_cnt == CNT_W'(1)) |=> (eob_pend && !dma_en));

  assert_off_no_req_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !dma_en |-> !mem_req);

  assert_prio_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (prio_q > compete_prio));

  assert_zero_count_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_en && cur_cnt == '0 && !cfg_we) |=> (eob_pend && !dma_en));

  assert_overrun_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_full && !xfer) |=> ovr_flag);
endmodule

bind rxdma_top rxdma_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cfg_we       (cfg_we),
  .rx_valid     (rx_valid),
  .mem_req      (mem_req),
  .mem_gnt      (mem_gnt),
  .rx_full      (rx_full),
  .dma_en       (dma_en),
  .eob_pend     (eob_pend),
  .ovr_flag     (ovr_flag),
  .cur_addr     (cur_addr),
  .cur_cnt      (cur_cnt),
  .prio_q       (prio_q),
  .compete_prio (compete_prio)
);

// File: tb/sim_rxdma_top.sv
`timescale 1ns/1ps
module sim_rxdma_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_we = 1'b0;
  logic [1:0] cfg_sel = 2'd0;
  logic [7:0] cfg_wdata = 8'd0;
  logic       rx_valid = 1'b0;
  logic [7:0] rx_data = 8'd0;
  logic [2:0] compete_prio = 3'd0;
  logic       mem_gnt = 1'b0;
  logic       mem_req;
  logic [7:0] mem_addr, mem_wdata;
  logic       rx_full, ovr_flag, eob_pend, dma_en;
  logic [7:0] cur_addr, cur_cnt;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  rxdma_top u0 (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cfgw(input logic [1:0] s, input logic [7:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = s; cfg_wdata = d;
    @(posedge clk); #1;
    cfg_we = 1'b0;
  endtask

  task automatic push(input logic [7:0] b);
    @(negedge clk);
    rx_valid = 1'b1; rx_data = b;
    @(posedge clk); #1;
    rx_valid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=expired expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] base, b;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    // R11 reset state
    chk("R11 en", dma_en, 0); chk("R11 eob", eob_pend, 0);
    chk("R11 ovr", ovr_flag, 0); chk("R11 full", rx_full, 0);
    chk("R11 addr", cur_addr, 0); chk("R11 cnt", cur_cnt, 0);
    chk("R1 idle req", mem_req, 0);

    // block sweeps: lengths 1..5, some wrap the pointer
    mem_gnt = 1'b1; compete_prio = 3'd0;
    cfgw(2'd3, 8'd3);
    for (int n = 1; n <= 5; n++) begin
      base = (n % 2) ? 8'hFE : 8'(n * 16);
      cfgw(2'd1, base);
      cfgw(2'd2, 8'(n));
      cfgw(2'd0, 8'h07);
      chk("R12 enable set", dma_en, 1);
      chk("R12 eob cleared", eob_pend, 0);
      for (int i = 0; i < n; i++) begin
        b = 8'hA0 ^ 8'(n * 16 + i);
        push(b);
        chk("R1 req", mem_req, 1);
        chk("R3 addr", mem_addr, 8'(base + i));
        chk("R3 data", mem_wdata, b);
        @(posedge clk); #1;
        chk("R2 flag cleared", rx_full, 0);
        chk("R4 pointer", cur_addr, 8'(base + i + 1));
        chk("R5 count", cur_cnt, 8'(n - i - 1));
        chk("R6 eob", eob_pend, (i == n - 1) ? 1 : 0);
        chk("R6 enable", dma_en, (i == n - 1) ? 0 : 1);
      end
      chk("R6 no req after end", mem_req, 0);
    end

    // priority sweep, no grant
    mem_gnt = 1'b0;
    cfgw(2'd1, 8'h40);
    cfgw(2'd2, 8'd2);
    cfgw(2'd0, 8'h07);
    push(8'h55);
    for (int p = 0; p < 8; p++) begin
      cfgw(2'd3, 8'(p));
      for (int c = 0; c < 8; c++) begin
        @(negedge clk); compete_prio = 3'(c); #1;
        chk("R8 priority", mem_req, (p > c) ? 1 : 0);
      end
    end
    @(negedge clk); compete_prio = 3'd0; #1;
    chk("R5 count held", cur_cnt, 2);

    // overrun
    push(8'h66);
    chk("R10 overrun", ovr_flag, 1);
    chk("R10 full", rx_full, 1);
    chk("R10 newest byte", mem_wdata, 8'h66);
    cfgw(2'd0, 8'h05);
    chk("R12 ovr cleared", ovr_flag, 0);
    chk("R12 en kept", dma_en, 1);

    // byte arrives in the cycle of a granted write
    @(negedge clk);
    mem_gnt = 1'b1; rx_valid = 1'b1; rx_data = 8'h77;
    @(posedge clk); #1;
    mem_gnt = 1'b0; rx_valid = 1'b0;
    chk("R2 flag kept", rx_full, 1);
    chk("R10 no overrun", ovr_flag, 0);
    chk("R4 pointer", cur_addr, 8'h41);
    chk("R4 count", cur_cnt, 1);
    chk("R3 next data", mem_wdata, 8'h77);

    // withdraw by software
    cfgw(2'd0, 8'h00);
    chk("R7 withdrawn", mem_req, 0);
    @(negedge clk); mem_gnt = 1'b1;
    @(posedge clk); #1;
    chk("R7 no write cnt", cur_cnt, 1);
    chk("R7 no write full", rx_full, 1);
    @(negedge clk); mem_gnt = 1'b0;

    // disable in the granted cycle
    cfgw(2'd0, 8'h01);
    chk("R7 req back", mem_req, 1);
    @(negedge clk);
    mem_gnt = 1'b1; cfg_we = 1'b1; cfg_sel = 2'd0; cfg_wdata = 8'h00;
    @(posedge clk); #1;
    mem_gnt = 1'b0; cfg_we = 1'b0;
    chk("R7 completes cnt", cur_cnt, 0);
    chk("R7 completes addr", cur_addr, 8'h42);
    chk("R7 completes full", rx_full, 0);
    chk("R6 eob", eob_pend, 1);

    // zero count
    push(8'h99);
    cfgw(2'd0, 8'h02);
    chk("R12 eob clear", eob_pend, 0);
    cfgw(2'd0, 8'h01);
    chk("R9 no req", mem_req, 0);
    @(posedge clk); #1;
    chk("R9 eob", eob_pend, 1);
    chk("R9 disabled", dma_en, 0);
    chk("R9 addr held", cur_addr, 8'h42);
    chk("R9 full held", rx_full, 1);

    // reset again
    @(negedge clk); rst_n = 1'b0;
    @(posedge clk); #1;
    rst_n = 1'b1;
    chk("R11 full", rx_full, 0); chk("R11 eob", eob_pend, 0);
    chk("R11 addr", cur_addr, 0);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule